// File: doc/BRIEF.md
# Fast-Mode Flash Command Decoder

This block sits behind the write port of a two-or-more-bank flash interface. It watches bus write cycles and turns them into commands. It recognises a standard four-cycle program (two unlock writes, a setup write and the address/data write). It recognises a shortened mode, entered with an unlock-prefixed command, in which a program needs only a setup write and the address/data write. It also recognises a per-bank query mode, in which reads from the selected bank return device information instead of array data.

A program request leaves the block as a one-cycle strobe carrying the target address and data. The array and its program timing are outside the block. The block then reports itself busy until an external completion pulse arrives. A combinational read-side select tells the data path, for each read, whether to take array data or query data. It also says whether to force the upper byte to zero.

Top module: `fast_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (read), and `prog_req`, `erase_err`, `rd_query` and `rd_upper_zero` are 0.
- R2: In read mode, the write sequence AAh@555h, 55h@2AAh, A0h@555h, then any write (PA/PD) raises `prog_req` for exactly one cycle after the fourth write. `prog_addr`/`prog_data` equal PA/PD. `mode` becomes 3 (busy).
- R3: During an unlock sequence, a write that does not match the expected address and data returns the decoder to read mode. A following setup write and data write issue no program.
- R4: In read mode, the writes AAh@555h, 55h@2AAh, 20h@555h enter fast mode (`mode` = 1). The bank of the 20h write is recorded as the fast-mode bank.
- R5: In fast mode, a write of A0h (any address) followed by one address/data write issues a program as in R2. After `prog_done`, `mode` returns to 1.
- R6: In fast mode, a write of 80h (erase setup) raises `erase_err` for one cycle. `mode` stays 1 and no program is issued.
- R7: Fast mode is left only by 90h written with the fast-mode bank, then 00h, which gives `mode` = 0. A 90h carrying another bank is ignored.
- R8: In read mode, a write of 98h enters query mode (`mode` = 2) for the bank of that write. `rd_query` is 1 only while `rd_bank` equals that bank.
- R9: `rd_upper_zero` is 1 exactly when `rd_query` is 1 and `word_mode` is 1.
- R10: Query mode is left only by a write of F0h. Any other write, including unlock and setup patterns, leaves `mode` at 2.
- R11: While busy, writes are ignored and `mode` stays 3 until `prog_done`. It then returns to the mode that issued the program.
- R12: `prog_req` never stays high for two consecutive cycles, and `prog_addr` is stable while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write cycle strobe, one cycle per bus write |
| wr_addr | input | ADDR_W | Write address |
| wr_bank | input | BANK_W | Bank addressed by the write |
| wr_data | input | DATA_W | Write data; commands use bits 7:0 |
| word_mode | input | 1 | 1 = 16-bit reads |
| rd_bank | input | BANK_W | Bank addressed by the current read |
| prog_done | input | 1 | Pulse: the requested program has finished |
| prog_req | output | 1 | One-cycle program request strobe |
| prog_addr | output | ADDR_W | Address of the requested program |
| prog_data | output | DATA_W | Data of the requested program |
| erase_err | output | 1 | One-cycle flag: erase command written in fast mode |
| mode | output | 2 | 0 read, 1 fast, 2 query, 3 busy |
| rd_query | output | 1 | 1 = current read takes query data |
| rd_upper_zero | output | 1 | 1 = force read bits 15:8 to zero |

## Verification
A wrong sequencer state shows at `mode` on the cycle after the offending write. For example, a missed unlock abort or a dropped fast-mode bank shows there, and so does a premature busy release, since every write moves the state by at most one step. A state that looks right but is internally wrong shows up later. It appears on the next write that should start a program: a program then appears (or fails to appear) on `prog_req`. Errors in the query bank register appear immediately on `rd_query` and `rd_upper_zero` when the bench switches `rd_bank` and `word_mode`, with no clock edge needed.

// File: rtl/fcd_pkg.sv
// Shared types and command codes for the fast-mode command decoder.
// Assumes commands are carried on the low byte of the write data.
package fcd_pkg;

    typedef enum logic [3:0] {
        S_READ, S_UNL1, S_UNL2, S_PSET, S_BUSY,
        S_FAST, S_FPSET, S_FRST, S_QUERY
    } seq_state_t;

    typedef enum logic [1:0] {
        MODE_READ  = 2'd0,
        MODE_FAST  = 2'd1,
        MODE_QUERY = 2'd2,
        MODE_BUSY  = 2'd3
    } mode_t;

    // Decoded view of one write cycle
    typedef struct packed {
        logic unl1;   // AAh at 555h
        logic unl2;   // 55h at 2AAh
        logic at555;  // address is 555h
        logic c_a0;
        logic c_20;
        logic c_80;
        logic c_90;
        logic c_00;
        logic c_98;
        logic c_f0;
    } cmd_t;

    localparam logic [7:0] CMD_UNL1  = 8'hAA;
    localparam logic [7:0] CMD_UNL2  = 8'h55;
    localparam logic [7:0] CMD_PSET  = 8'hA0;
    localparam logic [7:0] CMD_FAST  = 8'h20;
    localparam logic [7:0] CMD_ERASE = 8'h80;
    localparam logic [7:0] CMD_FRST1 = 8'h90;
    localparam logic [7:0] CMD_FRST2 = 8'h00;
    localparam logic [7:0] CMD_QRY   = 8'h98;
    localparam logic [7:0] CMD_RST   = 8'hF0;

endpackage

// File: rtl/fcd_match.sv
// Combinational classifier of one write cycle into command flags.
// Assumes only the low CMD_AW address bits take part in unlock matching.
module fcd_match
    import fcd_pkg::*;
#(
    parameter int CMD_AW = 11
) (
    input  logic [CMD_AW-1:0] addr,
    input  logic [7:0]        code,
    output cmd_t              cmd
);
    localparam logic [CMD_AW-1:0] ADDR_A = CMD_AW'(12'h555);
    localparam logic [CMD_AW-1:0] ADDR_B = CMD_AW'(12'h2AA);

    // Compare address and code against each known command
    always_comb begin
        cmd.at555 = (addr == ADDR_A);
        cmd.unl1  = (addr == ADDR_A) && (code == CMD_UNL1);
        cmd.unl2  = (addr == ADDR_B) && (code == CMD_UNL2);
        cmd.c_a0  = (code == CMD_PSET);
        cmd.c_20  = (code == CMD_FAST);
        cmd.c_80  = (code == CMD_ERASE);
        cmd.c_90  = (code == CMD_FRST1);
        cmd.c_00  = (code == CMD_FRST2);
        cmd.c_98  = (code == CMD_QRY);
        cmd.c_f0  = (code == CMD_RST);
    end
endmodule

// File: rtl/fcd_seq.sv
// Command sequencer: walks unlock, program, fast-mode and query sequences,
// issues program strobes and holds busy until completion.
// Assumes wr_en is a single-cycle strobe per bus write.
module fcd_seq
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 16,
    parameter int BANK_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [DATA_W-1:0] wr_data,
    input  cmd_t              cmd,
    input  logic              prog_done,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              erase_err,
    output mode_t             mode,
    output logic [BANK_W-1:0] query_bank
);
    seq_state_t        state;
    logic              ret_fast;
    logic [BANK_W-1:0] fast_bank;

    // State transitions, request strobe and captured fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_READ;
            ret_fast   <= 1'b0;
            fast_bank  <= '0;
            query_bank <= '0;
            prog_req   <= 1'b0;
            prog_addr  <= '0;
            prog_data  <= '0;
            erase_err  <= 1'b0;
        end else begin
            prog_req  <= 1'b0;
            erase_err <= 1'b0;
            case (state)
                S_READ: if (wr_en) begin
                    if (cmd.unl1) state <= S_UNL1;
                    else if (cmd.c_98) begin
                        state      <= S_QUERY;
                        query_bank <= wr_bank;
                    end
                end
                S_UNL1: if (wr_en) state <= cmd.unl2 ? S_UNL2 : S_READ;
                S_UNL2: if (wr_en) begin
                    if (cmd.at555 && cmd.c_a0) state <= S_PSET;
                    else if (cmd.at555 && cmd.c_20) begin
                        state     <= S_FAST;
                        fast_bank <= wr_bank;
                    end else state <= S_READ;
                end
                S_PSET, S_FPSET: if (wr_en) begin
                    prog_req  <= 1'b1;
                    prog_addr <= wr_addr;
                    prog_data <= wr_data;
                    ret_fast  <= (state == S_FPSET);
                    state     <= S_BUSY;
                end
                S_BUSY: if (prog_done) state <= ret_fast ? S_FAST : S_READ;
                S_FAST: if (wr_en) begin
                    if (cmd.c_a0) state <= S_FPSET;
                    else if (cmd.c_80) erase_err <= 1'b1;
                    else if (cmd.c_90 && wr_bank == fast_bank) state <= S_FRST;
                end
                S_FRST: if (wr_en) state <= cmd.c_00 ? S_READ : S_FAST;
                S_QUERY: if (wr_en && cmd.c_f0) state <= S_READ;
                default: state <= S_READ;
            endcase
        end
    end

    // Collapse sequencer states into the externally visible mode
    always_comb begin
        case (state)
            S_FAST, S_FPSET, S_FRST: mode = MODE_FAST;
            S_QUERY:                 mode = MODE_QUERY;
            S_BUSY:                  mode = MODE_BUSY;
            default:                 mode = MODE_READ;
        endcase
    end

    p_req_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req);
    p_addr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BUSY && !prog_done) |=> $stable(prog_addr));
    p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BUSY && !prog_done) |=> mode == MODE_BUSY);
    p_req_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> mode == MODE_BUSY);
    p_err_fast_r6: assert property (@(posedge clk) disable iff (!rst_n)
        erase_err |-> mode == MODE_FAST);
    p_query_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_QUERY && !(wr_en && cmd.c_f0)) |=> mode == MODE_QUERY);
endmodule

// File: rtl/fcd_readmux.sv
// Read-side select: chooses query or array data per read bank and
// forces the upper byte low for word-wide query reads. Purely combinational.
module fcd_readmux
    import fcd_pkg::*;
#(
    parameter int BANK_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_t             mode,
    input  logic [BANK_W-1:0] query_bank,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic              word_mode,
    output logic              rd_query,
    output logic              rd_upper_zero
);
    // Select the data source for the current read
    always_comb begin
        rd_query      = (mode == MODE_QUERY) && (rd_bank == query_bank);
        rd_upper_zero = rd_query && word_mode;
    end

    p_query_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_query |-> mode == MODE_QUERY);
endmodule

// File: rtl/fast_cmd_decoder.sv
// Top of the fast-mode flash command decoder: classifier, sequencer and
// read select. Assumes DATA_W >= 8 and CMD_AW <= ADDR_W.
module fast_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 16,
    parameter int BANK_W = 1,
    parameter int CMD_AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              word_mode,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic              prog_done,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              erase_err,
    output logic [1:0]        mode,
    output logic              rd_query,
    output logic              rd_upper_zero
);
    cmd_t              cmd;
    mode_t             mode_i;
    logic [BANK_W-1:0] query_bank;

    fcd_match #(.CMD_AW(CMD_AW)) i_match (
        .addr (wr_addr[CMD_AW-1:0]),
        .code (wr_data[7:0]),
        .cmd  (cmd)
    );

    fcd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_bank    (wr_bank),
        .wr_data    (wr_data),
        .cmd        (cmd),
        .prog_done  (prog_done),
        .prog_req   (prog_req),
        .prog_addr  (prog_addr),
        .prog_data  (prog_data),
        .erase_err  (erase_err),
        .mode       (mode_i),
        .query_bank (query_bank)
    );

    fcd_readmux #(.BANK_W(BANK_W)) i_rdmux (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode          (mode_i),
        .query_bank    (query_bank),
        .rd_bank       (rd_bank),
        .word_mode     (word_mode),
        .rd_query      (rd_query),
        .rd_upper_zero (rd_upper_zero)
    );

    assign mode = mode_i;
endmodule

// File: tb/test_fast_cmd_decoder.sv
module test_fast_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [20:0] wr_addr = '0;
    logic [0:0]  wr_bank = '0;
    logic [15:0] wr_data = '0;
    logic        word_mode = 1'b0;
    logic [0:0]  rd_bank = '0;
    logic        prog_done = 1'b0;
    logic        prog_req;
    logic [20:0] prog_addr;
    logic [15:0] prog_data;
    logic        erase_err;
    logic [1:0]  mode;
    logic        rd_query;
    logic        rd_upper_zero;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fast_cmd_decoder i_fast_cmd_decoder (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [20:0] a, input logic b, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_bank = b; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_prog();
        prog_done = 1'b1;
        @(negedge clk);
        prog_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 mode", mode, 0);
        chk("R1 req", prog_req, 0);
        chk("R1 err", erase_err, 0);
        chk("R1 query", {rd_query, rd_upper_zero}, 0);
    endtask

    task automatic t_std_prog();
        wr(21'h555, 0, 16'hAA); wr(21'h2AA, 0, 16'h55); wr(21'h555, 0, 16'hA0);
        chk("R2 no early req", prog_req, 0);
        wr(21'h1ABCD, 1, 16'hBEEF);
        chk("R2 req", prog_req, 1);
        chk("R2 addr", prog_addr, 21'h1ABCD);
        chk("R2 data", prog_data, 16'hBEEF);
        chk("R2 busy", mode, 3);
        @(negedge clk);
        chk("R12 single pulse", prog_req, 0);
        finish_prog();
        chk("R11 back to read", mode, 0);
    endtask

    task automatic t_unlock_abort();
        wr(21'h555, 0, 16'hAA); wr(21'h123, 0, 16'h55);
        wr(21'h555, 0, 16'hA0); wr(21'h00777, 0, 16'h1234);
        chk("R3 no req", prog_req, 0);
        chk("R3 read", mode, 0);
        wr(21'h555, 0, 16'hAA); wr(21'h2AA, 0, 16'h55); wr(21'h555, 0, 16'h40);
        wr(21'h00777, 0, 16'h1234);
        chk("R3 bad third cycle", {mode, prog_req}, 0);
    endtask

    task automatic t_fast();
        wr(21'h555, 0, 16'hAA); wr(21'h2AA, 0, 16'h55); wr(21'h555, 1, 16'h20);
        chk("R4 fast", mode, 1);
        wr(21'h000, 1, 16'hA0); wr(21'h00042, 1, 16'h5A5A);
        chk("R5 req", prog_req, 1);
        chk("R5 addr", prog_addr, 21'h00042);
        chk("R5 data", prog_data, 16'h5A5A);
        wr(21'h555, 1, 16'hAA);
        chk("R11 write ignored in busy", mode, 3);
        finish_prog();
        chk("R11 back to fast", mode, 1);
        wr(21'h555, 1, 16'h80);
        chk("R6 err", erase_err, 1);
        chk("R6 stays fast", {mode, prog_req}, {2'd1, 1'b0});
        @(negedge clk);
        chk("R6 err pulse", erase_err, 0);
        wr(21'h000, 0, 16'h90); wr(21'h000, 0, 16'h00);
        chk("R7 wrong bank ignored", mode, 1);
        wr(21'h000, 1, 16'h90); wr(21'h000, 1, 16'h12);
        chk("R7 bad second cycle", mode, 1);
        wr(21'h000, 1, 16'h90); wr(21'h000, 1, 16'h00);
        chk("R7 exit", mode, 0);
    endtask

    task automatic t_query();
        wr(21'h055, 1, 16'h98);
        chk("R8 query", mode, 2);
        rd_bank = 1; word_mode = 1; #1;
        chk("R8 sel", rd_query, 1);
        chk("R9 upper zero", rd_upper_zero, 1);
        word_mode = 0; #1;
        chk("R9 byte mode", {rd_query, rd_upper_zero}, 2'b10);
        rd_bank = 0; word_mode = 1; #1;
        chk("R8 other bank", {rd_query, rd_upper_zero}, 0);
        wr(21'h555, 1, 16'hAA); wr(21'h2AA, 1, 16'h55); wr(21'h555, 1, 16'hA0);
        wr(21'h00100, 1, 16'h0001);
        chk("R10 stays query", {mode, prog_req}, {2'd2, 1'b0});
        wr(21'h000, 1, 16'hF0);
        chk("R10 exit", mode, 0);
        rd_bank = 1; #1;
        chk("R8 after exit", rd_query, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_std_prog();
        t_unlock_abort();
        t_fast();
        t_query();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule